// File: doc/BRIEF.md
# Transmitter Idle-Mode Register Sequencer

This block sits between user logic and the 16-bit dynamic configuration port of a serial transceiver. When user logic raises the idle-mode request, the block rewrites the transmit driver-strength fields so that the output swing is attenuated for electrical-idle or beacon signalling. It also forces the pre- and post-emphasis fields to fixed default values. When the request falls, the block writes the driver fields back to their normal values and restores the emphasis settings that were in place before entry.

Every update is a read of the register followed by a masked write, so bits outside the target fields keep their current contents. The block covers lane A, lane B or both, chosen by a parameter. It holds a ready flag low for the whole of each sequence, and it passes the user idle-enable signal straight through to the transceiver. A request that changes while a sequence is running is picked up as soon as that sequence finishes.

Top module: `idle_seq`

## Requirements
- R1: `xcvr_idle_en_o` follows `user_idle_en_i` combinationally at all times, including while a sequence is running.
- R2: After reset `idle_ready_o` is 1, the block is in normal mode and it makes no configuration-port access.
- R3: On entry to idle mode the 5-bit tap field (bits 11:7 of 0x4C for lane A, 0x4E for lane B) becomes 5'b11111. The 3-bit pre-driver field becomes 3'b100. Bits 1:0 of that field are bits 15:14 of 0x4C/0x4E, and bit 2 is bit 0 of 0x54/0x56.
- R4: On exit from idle mode the tap field becomes 5'b01010 and the pre-driver field becomes 3'b111, at the same bit positions as in R3.
- R5: In idle mode the bits selected by the emphasis masks (defaults 0x007F at 0x4C/0x4E, 0x00FE at 0x54/0x56, 0x00FF at 0x5C/0x5E) hold the emphasis default values (defaults 0x0015, 0x0024, 0x0033). On exit they get back the values they had just before entry.
- R6: Bits outside the driver and emphasis fields of each touched register keep the value read at the start of that register's update.
- R7: `idle_ready_o` is 1 in steady normal mode and in steady idle mode. It is 0 while configuration accesses are in progress. No access starts while it is 1.
- R8: `idle_ready_o` falls at the first clock edge after the request differs from the current mode. Each address is read and then written. Only one access is outstanding at a time, and each waits for `cfg_rdy_i`.
- R9: A request change during a sequence takes effect once that sequence completes, with `idle_ready_o` held low throughout.
- R10: With lane selection at its default (both lanes), a sequence touches exactly 0x4C, 0x54, 0x5C, 0x4E, 0x56 and 0x5E, one read and one write each, and no other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Configuration clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| idle_req_i | input | 1 | Request idle (attenuated) mode when 1 |
| idle_ready_o | output | 1 | High when no mode change is in progress |
| user_idle_en_i | input | 1 | User transmit idle enable |
| xcvr_idle_en_o | output | 1 | Idle enable to the transceiver |
| cfg_addr_o | output | 8 | Configuration port address |
| cfg_wdata_o | output | 16 | Configuration port write data |
| cfg_en_o | output | 1 | Access strobe, one cycle |
| cfg_we_o | output | 1 | Write qualifier for `cfg_en_o` |
| cfg_rdata_i | input | 16 | Configuration port read data |
| cfg_rdy_i | input | 1 | Access complete pulse |

## Verification
The bench goes after the split pre-driver field. If only the high word were updated, 0x54 bit 0 would be wrong and the field would not read 100/111. It flips bits outside all fields between entry and exit. A design that wrote back whole saved words would then lose those flips, and one that skipped the read would clear them. It drops the request in the middle of an entry sequence. A design that aborted, or that raised ready between the two sequences, would show a second ready rise, a write count other than twelve, or emphasis left at the defaults. It also counts port accesses against a model that answers with latency, which catches overlapped strobes, writes without a prior read, and stray addresses.

// File: rtl/idle_seq_pkg.sv
package idle_seq_pkg;

  typedef logic [15:0] cfg_word_t;

  localparam int unsigned REGS_PER_LANE = 3;
  localparam logic [7:0]  LANE_STRIDE   = 8'h02;

  localparam logic [4:0] TAP_IDLE = 5'b11111;
  localparam logic [4:0] TAP_NORM = 5'b01010;
  localparam logic [2:0] PRE_IDLE = 3'b100;
  localparam logic [2:0] PRE_NORM = 3'b111;

  // lane A address of each register slot; lane B adds LANE_STRIDE
  function automatic logic [7:0] reg_base(input logic [1:0] idx);
    case (idx)
      2'd0:    return 8'h4C;
      2'd1:    return 8'h54;
      default: return 8'h5C;
    endcase
  endfunction

  function automatic cfg_word_t drv_mask(input logic [1:0] idx);
    case (idx)
      2'd0:    return 16'hCF80;
      2'd1:    return 16'h0001;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic cfg_word_t drv_value(input logic [1:0] idx, input logic idle);
    logic [2:0] pre;
    logic [4:0] tap;
    pre = idle ? PRE_IDLE : PRE_NORM;
    tap = idle ? TAP_IDLE : TAP_NORM;
    case (idx)
      2'd0:    return {pre[1:0], 2'b00, tap, 7'b0};
      2'd1:    return {15'b0, pre[2]};
      default: return 16'h0000;
    endcase
  endfunction

endpackage

// File: rtl/idle_field_merge.sv
module idle_field_merge
  import idle_seq_pkg::*;
#(
  parameter cfg_word_t EMPH_MASK0 = 16'h007F,
  parameter cfg_word_t EMPH_MASK1 = 16'h00FE,
  parameter cfg_word_t EMPH_MASK2 = 16'h00FF,
  parameter cfg_word_t EMPH_DEF0  = 16'h0015,
  parameter cfg_word_t EMPH_DEF1  = 16'h0024,
  parameter cfg_word_t EMPH_DEF2  = 16'h0033
) (
  input  logic [1:0] reg_idx_i,
  input  logic       to_idle_i,
  input  cfg_word_t  rd_word_i,
  input  cfg_word_t  shadow_word_i,
  output cfg_word_t  wr_word_o
);

  cfg_word_t emph_mask, emph_def, keep_mask, emph_part;

  always_comb begin
    case (reg_idx_i)
      2'd0:    begin emph_mask = EMPH_MASK0; emph_def = EMPH_DEF0; end
      2'd1:    begin emph_mask = EMPH_MASK1; emph_def = EMPH_DEF1; end
      default: begin emph_mask = EMPH_MASK2; emph_def = EMPH_DEF2; end
    endcase
    keep_mask = ~(drv_mask(reg_idx_i) | emph_mask);
    emph_part = to_idle_i ? (emph_def & emph_mask) : (shadow_word_i & emph_mask);
    wr_word_o = (rd_word_i & keep_mask) | drv_value(reg_idx_i, to_idle_i) | emph_part;
  end

endmodule

// File: rtl/idle_shadow_bank.sv
module idle_shadow_bank
  import idle_seq_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 6,
  localparam int unsigned SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  cfg_word_t         word_i,
  output cfg_word_t         word_o
);

  cfg_word_t shadow_q [NUM_SLOTS];

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                shadow_q[g] <= '0;
      else if (cap_i && (slot_i == SLOT_W'(g)))   shadow_q[g] <= word_i;
    end
  end

  always_comb begin
    word_o = '0;
    for (int i = 0; i < NUM_SLOTS; i++)
      if (slot_i == SLOT_W'(i)) word_o = shadow_q[i];
  end

endmodule

// File: rtl/idle_cfg_port.sv
module idle_cfg_port
  import idle_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] addr_i,
  input  cfg_word_t  wr_word_i,
  output cfg_word_t  rd_word_o,
  output logic       rd_ack_o,
  output logic       done_o,
  output logic       busy_o,
  output logic [7:0] cfg_addr_o,
  output cfg_word_t  cfg_wdata_o,
  output logic       cfg_en_o,
  output logic       cfg_we_o,
  input  cfg_word_t  cfg_rdata_i,
  input  logic       cfg_rdy_i
);

  typedef enum logic [2:0] {P_IDLE, P_RD_REQ, P_RD_WAIT, P_WR_REQ, P_WR_WAIT} port_st_e;
  port_st_e st_q;
  cfg_word_t rd_q;

  assign cfg_en_o    = (st_q == P_RD_REQ) || (st_q == P_WR_REQ);
  assign cfg_we_o    = (st_q == P_WR_REQ);
  assign cfg_addr_o  = addr_i;
  assign cfg_wdata_o = wr_word_i;
  assign rd_ack_o    = (st_q == P_RD_WAIT) && cfg_rdy_i;
  assign done_o      = (st_q == P_WR_WAIT) && cfg_rdy_i;
  assign busy_o      = (st_q != P_IDLE);
  assign rd_word_o   = rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= P_IDLE;
      rd_q <= '0;
    end else begin
      case (st_q)
        P_IDLE:    if (start_i) st_q <= P_RD_REQ;
        P_RD_REQ:  st_q <= P_RD_WAIT;
        P_RD_WAIT: if (cfg_rdy_i) begin
                     rd_q <= cfg_rdata_i;
                     st_q <= P_WR_REQ;
                   end
        P_WR_REQ:  st_q <= P_WR_WAIT;
        P_WR_WAIT: if (cfg_rdy_i) st_q <= start_i ? P_RD_REQ : P_IDLE;
        default:   st_q <= P_IDLE;
      endcase
    end
  end

  AST_EN_SINGLE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_en_o |=> !cfg_en_o); // R8

  AST_WRITE_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_en_o && cfg_we_o) |-> $past(rd_ack_o)); // R8

endmodule

// File: rtl/idle_seq.sv
module idle_seq
  import idle_seq_pkg::*;
#(
  parameter int unsigned LANE_SEL   = 2,  // 0: lane A, 1: lane B, 2: both
  parameter cfg_word_t   EMPH_MASK0 = 16'h007F,
  parameter cfg_word_t   EMPH_MASK1 = 16'h00FE,
  parameter cfg_word_t   EMPH_MASK2 = 16'h00FF,
  parameter cfg_word_t   EMPH_DEF0  = 16'h0015,
  parameter cfg_word_t   EMPH_DEF1  = 16'h0024,
  parameter cfg_word_t   EMPH_DEF2  = 16'h0033
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        idle_req_i,
  output logic        idle_ready_o,
  input  logic        user_idle_en_i,
  output logic        xcvr_idle_en_o,
  output logic [7:0]  cfg_addr_o,
  output logic [15:0] cfg_wdata_o,
  output logic        cfg_en_o,
  output logic        cfg_we_o,
  input  logic [15:0] cfg_rdata_i,
  input  logic        cfg_rdy_i
);

  localparam int unsigned NUM_LANES  = (LANE_SEL == 2) ? 2 : 1;
  localparam bit          FIRST_B    = (LANE_SEL == 1);
  localparam int unsigned NUM_SLOTS  = NUM_LANES * REGS_PER_LANE;
  localparam int unsigned SLOT_W     = $clog2(NUM_SLOTS);
  localparam logic        LAST_LANE  = 1'(NUM_LANES - 1);

  typedef enum logic {ST_STABLE, ST_BUSY} seq_st_e;

  seq_st_e           st_q;
  logic              mode_q, target_q;
  logic [1:0]        reg_q;
  logic              lane_q;
  logic              lane_phys, last_slot, seq_start;
  logic [SLOT_W-1:0] slot_idx;
  logic [7:0]        addr;
  cfg_word_t         rd_word, shadow_word, wr_word;
  logic              rd_ack, done, eng_busy;

  assign xcvr_idle_en_o = user_idle_en_i;
  assign idle_ready_o   = (st_q == ST_STABLE);

  assign lane_phys = FIRST_B ? 1'b1 : lane_q;
  assign addr      = reg_base(reg_q) + (lane_phys ? LANE_STRIDE : 8'h00);
  assign slot_idx  = lane_q ? (SLOT_W'(REGS_PER_LANE) + SLOT_W'(reg_q)) : SLOT_W'(reg_q);
  assign last_slot = (reg_q == 2'd2) && (lane_q == LAST_LANE);

  assign seq_start = ((st_q == ST_STABLE) && (idle_req_i != mode_q))
                   || (done && (!last_slot || (idle_req_i != target_q)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_STABLE;
      mode_q   <= 1'b0;
      target_q <= 1'b0;
      reg_q    <= '0;
      lane_q   <= 1'b0;
    end else begin
      case (st_q)
        ST_STABLE: if (idle_req_i != mode_q) begin
          target_q <= idle_req_i;
          reg_q    <= '0;
          lane_q   <= 1'b0;
          st_q     <= ST_BUSY;
        end
        ST_BUSY: if (done) begin
          if (!last_slot) begin
            if (reg_q == 2'd2) begin
              reg_q  <= '0;
              lane_q <= 1'b1;
            end else begin
              reg_q <= reg_q + 2'd1;
            end
          end else begin
            mode_q <= target_q;
            reg_q  <= '0;
            lane_q <= 1'b0;
            // a request that moved during the sequence starts the reverse one at once
            if (idle_req_i != target_q) target_q <= idle_req_i;
            else                        st_q     <= ST_STABLE;
          end
        end
        default: st_q <= ST_STABLE;
      endcase
    end
  end

  idle_cfg_port u_port (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (seq_start),
    .addr_i      (addr),
    .wr_word_i   (wr_word),
    .rd_word_o   (rd_word),
    .rd_ack_o    (rd_ack),
    .done_o      (done),
    .busy_o      (eng_busy),
    .cfg_addr_o  (cfg_addr_o),
    .cfg_wdata_o (cfg_wdata_o),
    .cfg_en_o    (cfg_en_o),
    .cfg_we_o    (cfg_we_o),
    .cfg_rdata_i (cfg_rdata_i),
    .cfg_rdy_i   (cfg_rdy_i)
  );

  idle_shadow_bank #(.NUM_SLOTS(NUM_SLOTS)) u_shadow (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cap_i  (rd_ack && target_q),
    .slot_i (slot_idx),
    .word_i (cfg_rdata_i),
    .word_o (shadow_word)
  );

  idle_field_merge #(
    .EMPH_MASK0 (EMPH_MASK0), .EMPH_MASK1 (EMPH_MASK1), .EMPH_MASK2 (EMPH_MASK2),
    .EMPH_DEF0  (EMPH_DEF0),  .EMPH_DEF1  (EMPH_DEF1),  .EMPH_DEF2  (EMPH_DEF2)
  ) u_merge (
    .reg_idx_i     (reg_q),
    .to_idle_i     (target_q),
    .rd_word_i     (rd_word),
    .shadow_word_i (shadow_word),
    .wr_word_o     (wr_word)
  );

  AST_QUIET_WHEN_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_ready_o |-> (!cfg_en_o && !eng_busy)); // R7

  AST_READY_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_ready_o && (idle_req_i != mode_q)) |=> !idle_ready_o); // R8

  AST_MODE_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mode_q) |-> $past(done && !idle_ready_o)); // R9

  AST_READY_MATCHES_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(idle_ready_o) |-> (mode_q == $past(idle_req_i))); // R9

endmodule

// File: tb/idle_seq_test.sv
module idle_seq_test;

  localparam int LAT = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        idle_req = 1'b0;
  logic        user_en = 1'b0;
  logic        ready, xcvr_en, en, we;
  logic [7:0]  addr;
  logic [15:0] wdata;
  logic [15:0] rdata = '0;
  logic        rdy = 1'b0;

  int vec_cnt = 0;
  int err_cnt = 0;

  always #2500 clk = ~clk;  // 200 MHz in 1 ps units

  idle_seq uut (
    .clk_i (clk), .rst_ni (rst_n), .idle_req_i (idle_req), .idle_ready_o (ready),
    .user_idle_en_i (user_en), .xcvr_idle_en_o (xcvr_en),
    .cfg_addr_o (addr), .cfg_wdata_o (wdata), .cfg_en_o (en), .cfg_we_o (we),
    .cfg_rdata_i (rdata), .cfg_rdy_i (rdy)
  );

  // configuration port model
  logic [15:0] mem [256];
  logic [15:0] orig [256];
  logic [15:0] cur  [256];
  logic        pend = 1'b0;
  int          cnt = 0;
  logic [7:0]  paddr = '0;
  logic        rd_open = 1'b0;
  logic [7:0]  last_rd = '0;
  int n_rd = 0, n_wr = 0, n_overlap = 0, n_order = 0, n_en_ready = 0, n_foreign = 0;
  int rises = 0;
  logic prev_ready = 1'b1;

  function automatic bit is_target(input logic [7:0] a);
    return a == 8'h4C || a == 8'h54 || a == 8'h5C || a == 8'h4E || a == 8'h56 || a == 8'h5E;
  endfunction

  always @(posedge clk) begin
    rdy <= 1'b0;
    if (en) begin
      if (pend) n_overlap++;
      if (ready) n_en_ready++;
      if (!is_target(addr)) n_foreign++;
      if (we) begin
        n_wr++;
        if (!rd_open || addr != last_rd) n_order++;
        rd_open <= 1'b0;
        mem[addr] <= wdata;
      end else begin
        n_rd++;
        rd_open <= 1'b1;
        last_rd <= addr;
      end
      pend  <= 1'b1;
      cnt   <= LAT - 1;
      paddr <= addr;
    end else if (pend) begin
      if (cnt == 0) begin
        rdy   <= 1'b1;
        rdata <= mem[paddr];
        pend  <= 1'b0;
      end else begin
        cnt <= cnt - 1;
      end
    end
  end

  always @(negedge clk) begin
    if (ready && !prev_ready) rises++;
    prev_ready <= ready;
  end

  task automatic check(input bit ok, input string rq, input logic [15:0] got, input logic [15:0] exp);
    vec_cnt++;
    if (!ok) begin
      err_cnt++;
      $display("FAIL %s: got %h expected %h", rq, got, exp);
    end
  endtask

  function automatic logic [7:0] slot_addr(input int lane, input int k);
    logic [7:0] b;
    b = (k == 0) ? 8'h4C : (k == 1) ? 8'h54 : 8'h5C;
    return b + 8'(2 * lane);
  endfunction

  function automatic logic [15:0] exp_idle(input int k, input logic [15:0] c);
    case (k)
      0:       return (c & 16'h3000) | 16'h0F80 | 16'h0015;
      1:       return (c & 16'hFF00) | 16'h0001 | 16'h0024;
      default: return (c & 16'hFF00) | 16'h0033;
    endcase
  endfunction

  function automatic logic [15:0] exp_norm(input int k, input logic [15:0] c, input logic [15:0] o);
    case (k)
      0:       return (c & 16'h3000) | 16'hC500 | (o & 16'h007F);
      1:       return (c & 16'hFF00) | 16'h0001 | (o & 16'h00FE);
      default: return (c & 16'hFF00) | (o & 16'h00FF);
    endcase
  endfunction

  task automatic clear_counts();
    n_rd = 0; n_wr = 0; n_overlap = 0; n_order = 0; n_en_ready = 0; n_foreign = 0; rises = 0;
  endtask

  task automatic wait_ready();
    int n = 0;
    @(negedge clk);
    while (!ready && n < 2000) begin
      @(negedge clk);
      n++;
    end
    check(ready, "R7 ready returns", 16'(ready), 16'h1);
  endtask

  task automatic check_port_rules(input string rq, input int exp_acc);
    check(n_rd == exp_acc && n_wr == exp_acc, {rq, " access count"}, 16'(n_rd + n_wr), 16'(2 * exp_acc));
    check(n_order == 0, "R8 read before write", 16'(n_order), 16'h0);
    check(n_overlap == 0, "R8 one outstanding", 16'(n_overlap), 16'h0);
    check(n_en_ready == 0, "R7 no access while ready", 16'(n_en_ready), 16'h0);
    check(n_foreign == 0, "R10 no foreign address", 16'(n_foreign), 16'h0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(ready, "R2 ready in reset", 16'(ready), 16'h1);
    rst_n = 1'b1;
    clear_counts();
    repeat (6) @(negedge clk);
    check(ready, "R2 ready after reset", 16'(ready), 16'h1);
    check(n_rd + n_wr == 0, "R2 no access after reset", 16'(n_rd + n_wr), 16'h0);
  endtask

  task automatic t_passthru();
    user_en = 1'b1; #1;
    check(xcvr_en == 1'b1, "R1 pass high", 16'(xcvr_en), 16'h1);
    user_en = 1'b0; #1;
    check(xcvr_en == 1'b0, "R1 pass low", 16'(xcvr_en), 16'h0);
  endtask

  task automatic t_enter();
    int bad = 0;
    for (int i = 0; i < 256; i++) orig[i] = mem[i];
    clear_counts();
    @(negedge clk);
    idle_req = 1'b1; #1;
    check(ready, "R8 ready before edge", 16'(ready), 16'h1);
    @(negedge clk);
    check(!ready, "R8 ready falls after one edge", 16'(ready), 16'h0);
    user_en = 1'b1; #1;
    check(xcvr_en == 1'b1, "R1 pass while busy", 16'(xcvr_en), 16'h1);
    user_en = 1'b0;
    wait_ready();
    for (int ln = 0; ln < 2; ln++)
      for (int k = 0; k < 3; k++) begin
        logic [7:0] a;
        a = slot_addr(ln, k);
        check(mem[a] == exp_idle(k, orig[a]), "R6 R5 idle word", mem[a], exp_idle(k, orig[a]));
      end
    check(mem[8'h4C][11:7] == 5'b11111, "R3 tap lane A", 16'(mem[8'h4C][11:7]), 16'h1F);
    check({mem[8'h56][0], mem[8'h4E][15:14]} == 3'b100, "R3 pre lane B",
          16'({mem[8'h56][0], mem[8'h4E][15:14]}), 16'h4);
    check((mem[8'h5E] & 16'h00FF) == 16'h0033, "R5 emphasis default", mem[8'h5E] & 16'h00FF, 16'h0033);
    for (int i = 0; i < 256; i++)
      if (!is_target(8'(i)) && mem[i] != orig[i]) bad++;
    check(bad == 0, "R10 other addresses unchanged", 16'(bad), 16'h0);
    check_port_rules("R10", 6);
    clear_counts();
    repeat (8) @(negedge clk);
    check(ready && n_rd + n_wr == 0, "R7 steady idle quiet", 16'(n_rd + n_wr), 16'h0);
  endtask

  task automatic t_exit();
    mem[8'h4C] = mem[8'h4C] ^ 16'h3000;
    mem[8'h54] = mem[8'h54] ^ 16'h5500;
    mem[8'h5E] = mem[8'h5E] ^ 16'hAA00;
    for (int i = 0; i < 256; i++) cur[i] = mem[i];
    clear_counts();
    @(negedge clk);
    idle_req = 1'b0;
    @(negedge clk);
    check(!ready, "R8 ready falls on exit", 16'(ready), 16'h0);
    wait_ready();
    for (int ln = 0; ln < 2; ln++)
      for (int k = 0; k < 3; k++) begin
        logic [7:0] a;
        a = slot_addr(ln, k);
        check(mem[a] == exp_norm(k, cur[a], orig[a]), "R6 R5 normal word", mem[a], exp_norm(k, cur[a], orig[a]));
      end
    check(mem[8'h4E][11:7] == 5'b01010, "R4 tap lane B", 16'(mem[8'h4E][11:7]), 16'h0A);
    check({mem[8'h54][0], mem[8'h4C][15:14]} == 3'b111, "R4 pre lane A",
          16'({mem[8'h54][0], mem[8'h4C][15:14]}), 16'h7);
    check((mem[8'h5C] & 16'h00FF) == (orig[8'h5C] & 16'h00FF), "R5 emphasis restored",
          mem[8'h5C] & 16'h00FF, orig[8'h5C] & 16'h00FF);
    check_port_rules("R10", 6);
  endtask

  task automatic t_midchange();
    for (int i = 0; i < 256; i++) orig[i] = mem[i];
    clear_counts();
    @(negedge clk);
    idle_req = 1'b1;
    repeat (4) @(negedge clk);
    idle_req = 1'b0;
    wait_ready();
    check(rises == 1, "R9 ready held low across both", 16'(rises), 16'h1);
    check(n_wr == 12, "R9 both sequences run", 16'(n_wr), 16'd12);
    for (int ln = 0; ln < 2; ln++)
      for (int k = 0; k < 3; k++) begin
        logic [7:0] a;
        a = slot_addr(ln, k);
        check(mem[a] == exp_norm(k, orig[a], orig[a]), "R9 final normal", mem[a], exp_norm(k, orig[a], orig[a]));
      end
    check_port_rules("R9", 12);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'(i * 16'h1357) ^ 16'hA5A5;
    t_reset();
    t_passthru();
    t_enter();
    t_exit();
    t_midchange();
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 16'h0, 16'h1);
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end

endmodule